// File: doc/BRIEF.md
# Hysteretic Lock Detector with Feedback Watchdog

This block produces the lock indication for a phase-locked clock generator. A separate phase comparator reports, once per feedback clock period, whether the reference-to-feedback phase gap exceeded the allowed delay limit. The detector turns this per-cycle flag into a stable lock level. It uses hysteresis, so a long run of clean cycles is needed to declare lock and a short run of errored cycles is enough to withdraw it.

The error flag is captured on the feedback clock. A toggle is carried into the reference clock domain, and all decisions are made there. A watchdog runs from a divided-down copy of the reference clock and withdraws lock when feedback edges stop arriving altogether. The feedback clock must be at most a quarter of the reference clock frequency, so that every feedback edge is seen as a separate event.

Top module: `lkd_lock_detect`

## Requirements
- R1: After reset `lock_o` is low, and both the clean-run count and the error-run count start from zero.
- R2: While unlocked, `lock_o` rises on the 32nd consecutive feedback cycle with `phase_err_i` low, and not before it.
- R3: While locked, `lock_o` falls on the 4th consecutive feedback cycle with `phase_err_i` high. One to three errored cycles in a row leave it high.
- R4: An error-free feedback cycle restarts the errored run, and an errored feedback cycle restarts the clean run.
- R5: While locked, if no feedback edge arrives, `lock_o` falls no earlier than 7×16 and no later than 8×16 reference cycles (plus synchronizer latency) after the last edge.
- R6: After the watchdog withdraws lock, a full run of 32 clean feedback cycles is needed to regain it.
- R7: Every feedback edge restarts the watchdog, so gaps shorter than the lower timeout bound never withdraw lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all lock decisions happen in this domain |
| fb_clk | input | 1 | Feedback clock; one rising edge per compared cycle |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| phase_err_i | input | 1 | Phase-limit exceeded for the current feedback cycle; sampled on the rising edge of `fb_clk` |
| lock_o | output | 1 | High when locked, low while lock is being acquired |

## Verification
The hardest case to reach from the ports is the watchdog window. The feedback clock has to stop completely while lock is held. The check must then show that `lock_o` stays high through most of the timeout and falls inside the window set by the prescaler phase. The bench drives feedback edges one at a time from a task instead of a free-running clock, so it can stop them, space them just inside the timeout, and resume them to show a fresh full clean run is needed to relock.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   typedef enum logic {
      ST_ACQUIRE = 1'b0,
      ST_LOCKED  = 1'b1
   } lkd_state_e;
endpackage

// File: rtl/lkd_fb_capture.sv
// Feedback-domain front end: one toggle and one captured error bit per edge.
module lkd_fb_capture (
   input  logic fb_clk,
   input  logic rst_n,
   input  logic phase_err_i,
   output logic fb_tgl_o,
   output logic err_q_o
);
   always_ff @(posedge fb_clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_tgl_o <= 1'b0;
         err_q_o  <= 1'b0;
      end else begin
         fb_tgl_o <= ~fb_tgl_o;
         err_q_o  <= phase_err_i;
      end
   end
endmodule

// File: rtl/lkd_event_sync.sv
// Reference-domain toggle synchronizer. It turns each feedback edge into a
// one-cycle event carrying the error bit captured with that edge.
module lkd_event_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic fb_tgl_i,
   input  logic err_q_i,
   output logic evt_o,
   output logic err_o
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;
   logic                   err_hold;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= fb_tgl_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q   <= 1'b0;
         err_hold <= 1'b0;
      end else begin
         last_q   <= chain[SYNC_STAGES-1];
         err_hold <= err_q_i;   // quasi-static: stable a whole feedback period
      end
   end

   assign evt_o = chain[SYNC_STAGES-1] ^ last_q;
   assign err_o = err_hold;

   // Two events in back-to-back cycles would mean the feedback edge rate is too high.
   AST_EVT_SPACED: assert property (@(posedge ref_clk) disable iff (!rst_n)
      evt_o |=> !evt_o); // R7
endmodule

// File: rtl/lkd_watchdog.sv
// Divided-reference timeout that fires when feedback events stop.
module lkd_watchdog #(
   parameter int DIV   = 16,
   parameter int TICKS = 8
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic evt_i,
   output logic expired_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int TW = $clog2(TICKS + 1);
   localparam logic [TW-1:0] TICK_LIM = TW'(TICKS);

   initial begin
      if (DIV < 2)   $error("DIV must be at least 2");
      if (TICKS < 2) $error("TICKS must be at least 2");
   end

   logic [PW-1:0] pre_q;
   logic          tick;
   logic [TW-1:0] tick_cnt;

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      // Power-of-two divide: free-running wrap, tick on all-ones.
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) pre_q <= '0;
         else        pre_q <= pre_q + 1'b1;
      end
      assign tick = &pre_q;
   end else begin : g_modn
      localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n)                pre_q <= '0;
         else if (pre_q == PRE_LAST) pre_q <= '0;
         else                        pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_LAST);
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                            tick_cnt <= '0;
      else if (evt_i)                        tick_cnt <= '0;
      else if (tick && tick_cnt != TICK_LIM) tick_cnt <= tick_cnt + 1'b1;
   end

   assign expired_o = (tick_cnt == TICK_LIM);

   AST_WD_RESTART: assert property (@(posedge ref_clk) disable iff (!rst_n)
      evt_i |=> (tick_cnt == '0)); // R7
   AST_WD_SATURATE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (expired_o && !evt_i) |=> expired_o); // R5
endmodule

// File: rtl/lkd_lock_fsm.sv
// Two-state hysteresis machine with separate clean-run and error-run counters.
module lkd_lock_fsm
   import lkd_pkg::*;
#(
   parameter int GAIN_CYCLES = 32,
   parameter int LOSE_CYCLES = 4
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic err_i,
   input  logic wd_expired_i,
   output logic lock_o
);
   localparam int GW = $clog2(GAIN_CYCLES);
   localparam int BW = $clog2(LOSE_CYCLES);
   localparam logic [GW-1:0] GOOD_LAST = GW'(GAIN_CYCLES - 1);
   localparam logic [BW-1:0] BAD_LAST  = BW'(LOSE_CYCLES - 1);

   initial begin
      if (GAIN_CYCLES < 2) $error("GAIN_CYCLES must be at least 2");
      if (LOSE_CYCLES < 2) $error("LOSE_CYCLES must be at least 2");
   end

   lkd_state_e    state;
   logic [GW-1:0] good_cnt;
   logic [BW-1:0] bad_cnt;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_ACQUIRE;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else if (wd_expired_i && state == ST_LOCKED) begin
         state    <= ST_ACQUIRE;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else if (evt_i) begin
         case (state)
            ST_ACQUIRE: begin
               bad_cnt <= '0;
               if (err_i) begin
                  good_cnt <= '0;
               end else if (good_cnt == GOOD_LAST) begin
                  state    <= ST_LOCKED;
                  good_cnt <= '0;
               end else begin
                  good_cnt <= good_cnt + 1'b1;
               end
            end
            default: begin
               good_cnt <= '0;
               if (!err_i) begin
                  bad_cnt <= '0;
               end else if (bad_cnt == BAD_LAST) begin
                  state   <= ST_ACQUIRE;
                  bad_cnt <= '0;
               end else begin
                  bad_cnt <= bad_cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign lock_o = (state == ST_LOCKED);

   AST_LOCK_RISE_CLEAN: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(evt_i && !err_i)); // R2
   AST_LOCK_FALL_CAUSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(lock_o) |-> $past(wd_expired_i || (evt_i && err_i))); // R3
   AST_ERR_CLEARS_GOOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!lock_o && evt_i && err_i && !wd_expired_i) |=> (good_cnt == '0 && !lock_o)); // R4
   AST_WD_DROPS: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (lock_o && wd_expired_i) |=> !lock_o); // R5
endmodule

// File: rtl/lkd_lock_detect.sv
module lkd_lock_detect #(
   parameter int GAIN_CYCLES = 32,
   parameter int LOSE_CYCLES = 4,
   parameter int WD_DIV      = 16,
   parameter int WD_TICKS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic fb_clk,
   input  logic rst_n,
   input  logic phase_err_i,
   output logic lock_o
);
   logic fb_tgl, err_q, evt, evt_err, wd_expired;

   lkd_fb_capture u_cap (
      .fb_clk      (fb_clk),
      .rst_n       (rst_n),
      .phase_err_i (phase_err_i),
      .fb_tgl_o    (fb_tgl),
      .err_q_o     (err_q)
   );

   lkd_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .fb_tgl_i (fb_tgl),
      .err_q_i  (err_q),
      .evt_o    (evt),
      .err_o    (evt_err)
   );

   lkd_watchdog #(.DIV(WD_DIV), .TICKS(WD_TICKS)) u_wd (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .expired_o (wd_expired)
   );

   lkd_lock_fsm #(.GAIN_CYCLES(GAIN_CYCLES), .LOSE_CYCLES(LOSE_CYCLES)) u_fsm (
      .ref_clk      (ref_clk),
      .rst_n        (rst_n),
      .evt_i        (evt),
      .err_i        (evt_err),
      .wd_expired_i (wd_expired),
      .lock_o       (lock_o)
   );

   AST_RESET_UNLOCKED: assert property (@(posedge ref_clk)
      !rst_n |-> !lock_o); // R1
endmodule

// File: tb/tb_lkd_lock_detect.sv
module tb_lkd_lock_detect;
   logic ref_clk = 1'b0;
   logic fb_clk  = 1'b0;
   logic rst_n   = 1'b0;
   logic phase_err_i = 1'b0;
   logic lock_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 ref_clk = ~ref_clk;   // 125 MHz

   lkd_lock_detect dut (
      .ref_clk     (ref_clk),
      .fb_clk      (fb_clk),
      .rst_n       (rst_n),
      .phase_err_i (phase_err_i),
      .lock_o      (lock_o)
   );

   // Run table: error level, run length, expected lock after each cycle, tag code
   typedef struct packed {
      logic       err;
      logic [5:0] len;
      logic       exp;
      logic [1:0] tag;   // 0:R2 1:R3 2:R4
   } run_t;

   localparam int NRUN = 10;
   localparam run_t RUNS [NRUN] = '{
      '{1'b0, 6'd31, 1'b0, 2'd0},   // R2: 31 clean, still unlocked
      '{1'b0, 6'd1,  1'b1, 2'd0},   // R2: 32nd clean locks
      '{1'b1, 6'd3,  1'b1, 2'd1},   // R3: three errors keep lock
      '{1'b0, 6'd1,  1'b1, 2'd2},   // R4: clean cycle restarts error run
      '{1'b1, 6'd3,  1'b1, 2'd2},   // R4: three more errors still locked
      '{1'b1, 6'd1,  1'b0, 2'd1},   // R3: fourth consecutive error drops
      '{1'b0, 6'd20, 1'b0, 2'd2},   // R4: partial clean run
      '{1'b1, 6'd1,  1'b0, 2'd2},   // R4: error restarts clean run
      '{1'b0, 6'd31, 1'b0, 2'd2},   // R4: 31 clean after the error, unlocked
      '{1'b0, 6'd1,  1'b1, 2'd2}    // R4: 32nd clean after the error locks
   };

   function automatic string tag_name(input logic [1:0] t);
      case (t)
         2'd0:    return "R2";
         2'd1:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: lock_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One feedback cycle; returns between reference edges, well after the update.
   task automatic fb_cycle(input logic err);
      @(negedge ref_clk);
      phase_err_i = err;
      #21 fb_clk = 1'b1;
      #32 fb_clk = 1'b0;
      #33;
   endtask

   task automatic idle_ref(input int n);
      repeat (n) @(posedge ref_clk);
      #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, lock_o=%b expected finish", lock_o);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle_ref(3);
      check("R1", lock_o, 1'b0);            // R1 in reset
      rst_n = 1'b1;
      idle_ref(2);
      check("R1", lock_o, 1'b0);            // R1 after release

      // Table walk: every feedback cycle checked
      for (int r = 0; r < NRUN; r++) begin
         for (int k = 0; k < int'(RUNS[r].len); k++) begin
            fb_cycle(RUNS[r].err);
            check(tag_name(RUNS[r].tag), lock_o, RUNS[r].exp);
         end
      end

      // R7: gaps of about 100 reference cycles, under the 112-cycle lower bound
      for (int g = 0; g < 3; g++) begin
         idle_ref(90);
         fb_cycle(1'b0);
         check("R7", lock_o, 1'b1);
      end

      // R5: feedback stops while locked
      idle_ref(100);
      check("R5", lock_o, 1'b1);             // too early to time out
      idle_ref(50);
      check("R5", lock_o, 1'b0);             // past 8*16 plus latency

      // R6: relock needs a full fresh clean run
      for (int k = 0; k < 31; k++) begin
         fb_cycle(1'b0);
         check("R6", lock_o, 1'b0);
      end
      fb_cycle(1'b0);
      check("R6", lock_o, 1'b1);

      // R1: reset mid-lock clears state and counts
      rst_n = 1'b0;
      idle_ref(2);
      check("R1", lock_o, 1'b0);
      rst_n = 1'b1;
      for (int k = 0; k < 31; k++) fb_cycle(1'b0);
      check("R1", lock_o, 1'b0);
      fb_cycle(1'b0);
      check("R1", lock_o, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule